// File: doc/BRIEF.md
# Serial Backlight and Panel-Mode Register Slave

This block is a receive-only serial slave for a display panel's timing logic. A host shifts 8-bit command words into it over a three-wire serial link made of an active-low select, a clock and a data line. Each word carries a register address in its top three bits and five data bits below them. Two of the eight addresses have an effect here: one picks the panel resolution mode (QVGA or VGA), and one sets the low five bits of the backlight level. Words sent to the other six addresses are accepted and dropped. The serial data output always stays at zero.

The 6-bit backlight level has two sources. Bits 4:0 come from the serial duty register. Bit 5 comes from an active-low general-purpose input, so driving that line high removes the upper half of the range. A second general-purpose input is the backlight enable. The block reports the level, the power state and whether the backlight is lit. From these it drives a pulse-width output. The PWM period is 63 clocks and the high time is the effective level. All serial and general-purpose inputs are asynchronous to the block clock and are synchronised inside the block.

Top module: `panel_bl_spi_ctl`

## Requirements
- R1: A word is 8 bits, sent MSB first, sampled on each rising edge of `spi_sclk` while `spi_cs_n` is low. The word is taken on the 8th rising edge. Bits 7:5 are the address and bits 4:0 are the data.
- R2: If `spi_cs_n` goes high before the 8th edge, the partial word is discarded. The next word starts from bit 7 again.
- R3: A word to address 0 sets `qvga_mode` to 1 if its data is nonzero and to 0 if its data is zero.
- R4: A word to address 2 replaces `bl_level[4:0]` with its data and leaves `bl_level[5]` unchanged.
- R5: Words to addresses 1, 3, 4, 5, 6 and 7 change neither `bl_level` nor `qvga_mode`.
- R6: `bl_level[5]` is the inverse of `bl_msb_n`: a high input clears it and a low input sets it. The change appears within 3 clocks.
- R7: After reset, `bl_level` is 0x20, `bl_power` is 0, `qvga_mode` is 0 (VGA), `bl_on` is 0 and `pwm_out` is low.
- R8: `bl_power` follows the level of `bl_en` within 3 clocks.
- R9: `bl_on` is 1 exactly when `bl_power` is 1 and `bl_level` is nonzero.
- R10: `pwm_out` has a period of 63 clocks. Within any 63 consecutive clocks it is high for exactly L clocks, where L is `bl_level` when `bl_on` is 1 and 0 otherwise. A level of 63 keeps the output high all the time.
- R11: `spi_miso` is 0 at all times.
- R12: Several words sent while `spi_cs_n` stays low are each decoded in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| spi_mosi | input | 1 | Serial data in, MSB first |
| spi_miso | output | 1 | Serial data out, held at zero |
| bl_msb_n | input | 1 | Active-low source of backlight level bit 5 |
| bl_en | input | 1 | Backlight enable level |
| qvga_mode | output | 1 | 1 = QVGA, 0 = VGA |
| bl_level | output | 6 | Backlight level |
| bl_power | output | 1 | Synchronised backlight enable |
| bl_on | output | 1 | Backlight lit (powered and nonzero level) |
| pwm_out | output | 1 | Backlight pulse-width output |

## Verification
The two functions that can act in the same cycle are the serial duty write and the general-purpose update of level bit 5. Both write fields of one 6-bit level. The bench provokes a collision by toggling `bl_msb_n` one clock after the final serial clock edge of a duty word. The synchronised input change then reaches the level register on the same clock as the decoded word. The bench judges the result by requiring `bl_level` to equal the new inverted bit 5 above the new five data bits. Random words and random input levels then repeat this overlap at arbitrary phases, and each result is checked against a bench model.

// File: rtl/panel_bl_pkg.sv
// Shared sizes and the register address map for the panel backlight slave.
package panel_bl_pkg;
    localparam int WORD_W   = 8;                    // serial word length
    localparam int ADDR_W   = 3;                    // address field width
    localparam int DATA_W   = WORD_W - ADDR_W;      // data field width
    localparam int LEVEL_W  = DATA_W + 1;           // backlight level width
    localparam int SYNC_N   = 2;                    // synchroniser depth

    // Register addresses; only MODE and DUTY have an effect here.
    typedef enum logic [ADDR_W-1:0] {
        ADR_MODE   = 3'd0,
        ADR_PHASE  = 3'd1,
        ADR_DUTY   = 3'd2,
        ADR_VCOM_A = 3'd3,
        ADR_VCOM_B = 3'd4,
        ADR_OUTS   = 3'd5,
        ADR_PICT   = 3'd6,
        ADR_POLAR  = 3'd7
    } panel_adr_e;
endpackage

// File: rtl/panel_sync.sv
// Multi-bit level synchroniser.
// Assumes: each bit is an independent slow level; no bus coherence is required.
module panel_sync #(
    parameter int               WIDTH  = 1,
    parameter int               STAGES = 2,
    parameter logic [WIDTH-1:0] RST_V  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] st;

    // First stage captures the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) st[0] <= RST_V;
        else        st[0] <= d;
    end

    genvar i;
    generate
        for (i = 1; i < STAGES; i++) begin : g_stage
            // Each later stage retimes the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) st[i] <= RST_V;
                else        st[i] <= st[i-1];
            end
        end
    endgenerate

    assign q = st[STAGES-1];
endmodule

// File: rtl/panel_spi_rx.sv
// Serial word receiver working on synchronised select, clock and data.
// Assumes: serial clock is slow against clk (at least 3 clk per phase);
// MSB first; a word is complete on the WORD_W-th rising edge.
module panel_spi_rx #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              mosi_s,
    output logic              word_vld,
    output logic [WORD_W-1:0] word
);
    localparam int                BIT_W    = $clog2(WORD_W);
    localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(WORD_W - 1);

    logic              sclk_q;
    logic              rise;
    logic [BIT_W-1:0]  cnt_q;
    logic [WORD_W-2:0] shift_q;

    // Delayed serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    assign rise = sclk_s & ~sclk_q & ~cs_n_s;

    // Bit counter, shifter and word strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            shift_q  <= '0;
            word     <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (cs_n_s) begin
                cnt_q <= '0;
            end else if (rise) begin
                if (cnt_q == LAST_BIT) begin
                    word     <= {shift_q, mosi_s};
                    word_vld <= 1'b1;
                    cnt_q    <= '0;
                end else begin
                    shift_q <= {shift_q[WORD_W-3:0], mosi_s};
                    cnt_q   <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/panel_reg_bank.sv
// Decodes received words and holds the mode flag, the backlight level and power.
// Assumes: msb_n_s and en_s are already synchronised; one word strobe per cycle.
module panel_reg_bank
    import panel_bl_pkg::*;
#(
    parameter int WORD_W  = panel_bl_pkg::WORD_W,
    parameter int DATA_W  = panel_bl_pkg::DATA_W,
    parameter int LEVEL_W = panel_bl_pkg::LEVEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               word_vld,
    input  logic [WORD_W-1:0]  word,
    input  logic               msb_n_s,
    input  logic               en_s,
    output logic               qvga,
    output logic [LEVEL_W-1:0] level,
    output logic               power
);
    panel_adr_e          adr;
    logic [DATA_W-1:0]   data;
    logic [DATA_W-1:0]   duty_q;
    logic                msb_q;

    assign adr  = panel_adr_e'(word[WORD_W-1:DATA_W]);
    assign data = word[DATA_W-1:0];

    // Register writes from the serial side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qvga   <= 1'b0;
            duty_q <= '0;
        end else if (word_vld) begin
            case (adr)
                ADR_MODE: qvga   <= |data;
                ADR_DUTY: duty_q <= data;
                default:  ;
            endcase
        end
    end

    // Level MSB and power follow the general-purpose lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msb_q <= 1'b1;
            power <= 1'b0;
        end else begin
            msb_q <= ~msb_n_s;
            power <= en_s;
        end
    end

    assign level = {msb_q, duty_q};
endmodule

// File: rtl/panel_bl_pwm.sv
// Free-running pulse-width generator with period 2**LEVEL_W-1 clocks.
// Assumes: duty is a stable level; duty equal to the period gives constant high.
module panel_bl_pwm #(
    parameter int LEVEL_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LEVEL_W-1:0] duty,
    output logic               pwm_out,
    output logic [LEVEL_W-1:0] phase
);
    localparam int                 PERIOD = (1 << LEVEL_W) - 1;
    localparam logic [LEVEL_W-1:0] LAST   = LEVEL_W'(PERIOD - 1);

    // Phase counter wraps after PERIOD clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)              phase <= '0;
        else if (phase == LAST)  phase <= '0;
        else                     phase <= phase + 1'b1;
    end

    // Registered compare keeps the output glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_out <= 1'b0;
        else        pwm_out <= (phase < duty);
    end
endmodule

// File: rtl/panel_bl_spi_ctl.sv
// Top: serial register slave for panel mode and backlight level with PWM drive.
// Assumes: all inputs except clk and rst_n are asynchronous; reset is synchronous.
module panel_bl_spi_ctl
    import panel_bl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_cs_n,
    input  logic               spi_sclk,
    input  logic               spi_mosi,
    output logic               spi_miso,
    input  logic               bl_msb_n,
    input  logic               bl_en,
    output logic               qvga_mode,
    output logic [LEVEL_W-1:0] bl_level,
    output logic               bl_power,
    output logic               bl_on,
    output logic               pwm_out
);
    localparam int            SYNC_W   = 5;
    localparam logic [SYNC_W-1:0] SYNC_RST = 5'b00100; // select idles high

    logic [SYNC_W-1:0]  raw, synced;
    logic               word_vld;
    logic [WORD_W-1:0]  word;
    logic [LEVEL_W-1:0] eff_duty;
    logic [LEVEL_W-1:0] pwm_phase;

    assign raw = {bl_en, bl_msb_n, spi_cs_n, spi_sclk, spi_mosi};

    panel_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_N), .RST_V(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
    );

    panel_spi_rx #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .cs_n_s(synced[2]), .sclk_s(synced[1]), .mosi_s(synced[0]),
        .word_vld(word_vld), .word(word)
    );

    panel_reg_bank u_regs (
        .clk(clk), .rst_n(rst_n),
        .word_vld(word_vld), .word(word),
        .msb_n_s(synced[3]), .en_s(synced[4]),
        .qvga(qvga_mode), .level(bl_level), .power(bl_power)
    );

    // Lit only when powered with a nonzero level.
    assign bl_on    = bl_power & (|bl_level);
    assign eff_duty = bl_on ? bl_level : '0;

    panel_bl_pwm #(.LEVEL_W(LEVEL_W)) u_pwm (
        .clk(clk), .rst_n(rst_n), .duty(eff_duty),
        .pwm_out(pwm_out), .phase(pwm_phase)
    );

    assign spi_miso = 1'b0;
endmodule

// Checker for the top module; attached through the bind below.
module panel_bl_spi_ctl_chk
    import panel_bl_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               spi_miso,
    input logic               word_vld,
    input logic [WORD_W-1:0]  word,
    input logic               qvga_mode,
    input logic [LEVEL_W-1:0] bl_level,
    input logic               bl_on,
    input logic               pwm_out,
    input logic [LEVEL_W-1:0] pwm_phase
);
    localparam logic [ADDR_W-1:0]  A_MODE = 3'd0;
    localparam logic [ADDR_W-1:0]  A_DUTY = 3'd2;
    localparam logic [LEVEL_W-1:0] PH_MAX = LEVEL_W'((1 << LEVEL_W) - 2);

    a_r11_miso_low: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso == 1'b0);

    a_r3_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld && word[WORD_W-1:DATA_W] == A_MODE
        |=> qvga_mode == ($past(word[DATA_W-1:0]) != '0));

    a_r4_duty_write: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld && word[WORD_W-1:DATA_W] == A_DUTY
        |=> bl_level[DATA_W-1:0] == $past(word[DATA_W-1:0]));

    a_r5_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_vld && word[WORD_W-1:DATA_W] == A_DUTY)
        |=> $stable(bl_level[DATA_W-1:0]));

    a_r5_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_vld && word[WORD_W-1:DATA_W] == A_MODE)
        |=> $stable(qvga_mode));

    a_r10_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_phase <= PH_MAX);

    a_r10_dark_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bl_on) |-> !pwm_out);
endmodule

bind panel_bl_spi_ctl panel_bl_spi_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .spi_miso(spi_miso),
    .word_vld(word_vld), .word(word), .qvga_mode(qvga_mode),
    .bl_level(bl_level), .bl_on(bl_on), .pwm_out(pwm_out),
    .pwm_phase(pwm_phase)
);

// File: tb/tb_panel_bl_spi_ctl.sv
module tb_panel_bl_spi_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
    logic       spi_miso;
    logic       bl_msb_n = 1'b0, bl_en = 1'b0;
    logic       qvga_mode, bl_power, bl_on, pwm_out;
    logic [5:0] bl_level;

    int n_checks = 0, n_fails = 0;
    bit done = 0;

    // Bench model
    bit       m_qvga = 0;
    bit [4:0] m_low  = 0;

    always #5 clk = ~clk;

    panel_bl_spi_ctl dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .bl_msb_n(bl_msb_n),
        .bl_en(bl_en), .qvga_mode(qvga_mode), .bl_level(bl_level),
        .bl_power(bl_power), .bl_on(bl_on), .pwm_out(pwm_out)
    );

    function automatic logic [5:0] exp_level();
        return {~bl_msb_n, m_low};
    endfunction

    function automatic int exp_duty();
        logic [5:0] l = exp_level();
        return (bl_en && l != 0) ? int'(l) : 0;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic model_word(input logic [7:0] w);
        if (w[7:5] == 3'd0) m_qvga = (w[4:0] != 0);
        if (w[7:5] == 3'd2) m_low  = w[4:0];
    endtask

    // Send nbits of w, MSB first; optionally flip bl_msb_n one clock after the last rise.
    task automatic spi_bits(input logic [7:0] w, input int nbits, input bit flip);
        for (int i = 7; i > 7 - nbits; i--) begin
            spi_mosi = w[i];
            spi_sclk = 1'b0;
            wait_clk(4);
            spi_sclk = 1'b1;
            if (flip && i == 0) begin
                wait_clk(1);
                bl_msb_n = ~bl_msb_n;
                wait_clk(3);
            end else begin
                wait_clk(4);
            end
        end
        spi_sclk = 1'b0;
        wait_clk(4);
    endtask

    task automatic spi_word(input logic [7:0] w);
        spi_cs_n = 1'b0;
        wait_clk(4);
        spi_bits(w, 8, 1'b0);
        spi_cs_n = 1'b1;
        wait_clk(6);
        model_word(w);
    endtask

    task automatic check_state(input string req);
        check(bl_level == exp_level(), {req, " level"}, bl_level, exp_level());
        check(qvga_mode == m_qvga, {req, " mode"}, qvga_mode, m_qvga);
        check(bl_power == bl_en, {req, " power R8"}, bl_power, bl_en);
        check(bl_on == (exp_duty() != 0), {req, " on R9"}, bl_on, exp_duty() != 0);
        check(spi_miso == 1'b0, {req, " miso R11"}, spi_miso, 0);
    endtask

    task automatic check_pwm(input string req);
        int highs = 0;
        wait_clk(4);
        for (int k = 0; k < 63; k++) begin
            wait_clk(1);
            if (pwm_out) highs++;
        end
        check(highs == exp_duty(), req, highs, exp_duty());
    endtask

    // Watchdog
    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);

        // R7 reset state
        check(bl_level == 6'h20, "R7 level", bl_level, 6'h20);
        check(bl_power == 1'b0, "R7 power", bl_power, 0);
        check(qvga_mode == 1'b0, "R7 mode", qvga_mode, 0);
        check(bl_on == 1'b0, "R7 on", bl_on, 0);
        check_pwm("R7 pwm dark");

        // R8, R9, R10: enable at the reset level 0x20
        bl_en = 1'b1;
        wait_clk(5);
        check_state("R8 enable");
        check_pwm("R10 duty 32");

        // R1, R4, R10: full scale
        spi_word({3'd2, 5'h1F});
        check_state("R1 R4 duty 31");
        check_pwm("R10 duty 63 full");

        // R6: msb input high clears bit 5
        bl_msb_n = 1'b1;
        wait_clk(3);
        check(bl_level == 6'h1F, "R6 msb cleared", bl_level, 6'h1F);
        check_pwm("R10 duty 31");

        // R9: zero level is dark even with power
        spi_word({3'd2, 5'h00});
        check_state("R9 zero level");
        check_pwm("R10 zero level");

        // R3 mode flag
        spi_word({3'd0, 5'h05});
        check_state("R3 qvga");
        spi_word({3'd0, 5'h00});
        check_state("R3 vga");
        spi_word({3'd0, 5'h10});
        check_state("R3 qvga msb data");

        // R5: other addresses ignored
        spi_word({3'd2, 5'h0A});
        for (int a = 1; a < 8; a++) begin
            if (a != 2) begin
                spi_word({3'(a), 5'h15});
                check_state($sformatf("R5 addr %0d", a));
            end
        end

        // R2: partial word dropped, next word starts fresh
        spi_cs_n = 1'b0;
        wait_clk(4);
        spi_bits({3'd0, 5'h1F}, 3, 1'b0);
        spi_cs_n = 1'b1;
        wait_clk(6);
        check_state("R2 after partial");
        spi_word({3'd2, 5'h13});
        check_state("R2 next word");

        // R12: two words in one select burst
        spi_cs_n = 1'b0;
        wait_clk(4);
        spi_bits({3'd2, 5'h07}, 8, 1'b0);
        spi_bits({3'd0, 5'h01}, 8, 1'b0);
        spi_cs_n = 1'b1;
        wait_clk(6);
        model_word({3'd2, 5'h07});
        model_word({3'd0, 5'h01});
        check_state("R12 burst");

        // R4 with R6 in the same cycle
        spi_cs_n = 1'b0;
        wait_clk(4);
        spi_bits({3'd2, 5'h19}, 8, 1'b1);
        spi_cs_n = 1'b1;
        wait_clk(6);
        model_word({3'd2, 5'h19});
        check_state("R4 R6 same cycle");
        check_pwm("R10 after collision");

        // Random words and input levels
        for (int it = 0; it < 40; it++) begin
            logic [7:0] w = 8'($urandom);
            bl_en = 1'($urandom);
            spi_cs_n = 1'b0;
            wait_clk(4);
            spi_bits(w, 8, 1'($urandom));
            spi_cs_n = 1'b1;
            wait_clk(6);
            model_word(w);
            check_state($sformatf("R1 R4 R5 R6 random %0d", it));
            if (it % 8 == 0) check_pwm("R10 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule